// File: doc/BRIEF.md
# Level-Sensitive Single-Channel DMA Sequencer

This block moves data in single units from a source address to a destination address. Each move is triggered by an active-low request line that an external device holds low. The line is treated as a level and is sampled on every clock, but only while an internal acceptance window is open. A sampled low level sets a held-request flag. The next cycle in which the bus is released consumes that flag and starts an activation.

An activation proceeds in a fixed order. The block raises a bus request and waits for grant. It then performs one read at the source, followed by one write of the read data to the destination, and then drops the bus request. The window stays shut from activation until the write has finished, and then reopens. This repeats until a programmed transfer count is used up. At that point the channel disables itself and gives a single-cycle completion pulse.

Software programs four word-wide registers through a simple write port: control, source, destination and count. The control register enables the channel, routes the request line into the engine, and selects address stepping for each side.

Top module: `dmaq_level_dma`

## Requirements
- R1: After reset, bus_req, bus_rd, bus_wr and done are low, and no bus cycle occurs while the channel has not been enabled, even with dreq_n held low.
- R2: When control bit 1 (request routing) is 0, the request line is ignored: the channel stays enabled, no bus cycle occurs and done stays low.
- R3: Sampling starts at the clock edge that ends the first cycle after the enabling control write (control bit 0 changing from 0 to 1). With dreq_n already low, bus_req is first high in the third cycle after the write cycle.
- R4: A low level on dreq_n that is sampled for only one clock while the window is open is held, and it produces exactly one transfer.
- R5: Capture and activation take at least two cycles. With dreq_n held low, exactly two bus-released cycles separate each write cycle from the next bus_req.
- R6: Each transfer raises bus_req, waits for bus_gnt, and then performs one bus_rd cycle addressed to the source. This is followed by one bus_wr cycle addressed to the destination, carrying the data that was read. bus_req drops after the write.
- R7: A request that is sampled low between activation and the end of the write cycle is ignored and does not cause an extra transfer.
- R8: After the number of transfers written to the count register (register 3), the channel disables itself. done is high for exactly one cycle, the cycle after the last write, and later requests cause no bus cycles.
- R9: The source and destination addresses each advance by STEP (2 by default) after each transfer when control bit 2 (source) or control bit 3 (destination) is 1. When the bit is 0, that address stays fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| cfg_wdata | input | AW | Register write data |
| dreq_n | input | 1 | Active-low level request |
| bus_req | output | 1 | Bus request, held through the read and write |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | AW | Read data |
| bus_wdata | output | AW | Write data |
| done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The bound checker watches several behaviours on every cycle. Read and write strobes must never overlap. Each read must be followed at once by a single write. A read may start only after a grant. A bus request may rise only after a held request. The window and the held flag must be closed during bus ownership. The held flag may rise only from an open-window low sample, and must stay clear while routing is off. The done pulse must be single. Only the bench scenarios can show the exact latency from the enabling write, the two-cycle gap under a continuous request, and the address stepping and data values. They also show that pulses during an activation are ignored and that the count stops the engine.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_RD, ST_WR} xfer_st_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SRC  = 2'd1;
  localparam logic [1:0] REG_DST  = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_LVL  = 1;
  localparam int CTRL_SINC = 2;
  localparam int CTRL_DINC = 3;
endpackage

// File: rtl/dmaq_ctrl_regs.sv
module dmaq_ctrl_regs
  import dmaq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          xfer_step,
  output logic          en_q,
  output logic          lvl_q,
  output logic          en_start,
  output logic          en_stop,
  output logic          last,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q
);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic          sinc_q, dinc_q;
  logic          en_d, lvl_d, sinc_d, dinc_d;
  logic [AW-1:0] src_d, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_ctrl, wr_src, wr_dst, wr_cnt;

  assign wr_ctrl = cfg_wr && (cfg_addr == REG_CTRL);
  assign wr_src  = cfg_wr && (cfg_addr == REG_SRC);
  assign wr_dst  = cfg_wr && (cfg_addr == REG_DST);
  assign wr_cnt  = cfg_wr && (cfg_addr == REG_CNT);
  assign last    = (cnt_q == ONE_C);

  always_comb begin
    en_d   = en_q;
    lvl_d  = lvl_q;
    sinc_d = sinc_q;
    dinc_d = dinc_q;
    if (wr_ctrl) begin
      en_d   = cfg_wdata[CTRL_RUN];
      lvl_d  = cfg_wdata[CTRL_LVL];
      sinc_d = cfg_wdata[CTRL_SINC];
      dinc_d = cfg_wdata[CTRL_DINC];
    end else if (xfer_step && last) begin
      en_d = 1'b0;
    end
  end

  assign en_start = !en_q && en_d;
  assign en_stop  = en_q && !en_d;

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    if (wr_src) src_d = cfg_wdata;
    else if (xfer_step && sinc_q) src_d = src_q + STEP_W;
    if (wr_dst) dst_d = cfg_wdata;
    else if (xfer_step && dinc_q) dst_d = dst_q + STEP_W;
    if (wr_cnt) cnt_d = cfg_wdata[CW-1:0];
    else if (xfer_step) cnt_d = cnt_q - ONE_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lvl_q  <= 1'b0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      lvl_q  <= lvl_d;
      sinc_q <= sinc_d;
      dinc_q <= dinc_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/dmaq_req_window.sv
module dmaq_req_window (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq_n,
  input  logic en_q,
  input  logic lvl_q,
  input  logic en_start,
  input  logic en_stop,
  input  logic act,
  input  logic xfer_step,
  output logic acc_open,
  output logic held
);
  logic open_d, held_d, sample_lo;

  assign sample_lo = acc_open && lvl_q && en_q && !dreq_n;

  always_comb begin
    open_d = acc_open;
    if (en_start)       open_d = 1'b1;
    else if (en_stop)   open_d = 1'b0;
    else if (act)       open_d = 1'b0;
    else if (xfer_step) open_d = 1'b1;
  end

  always_comb begin
    held_d = held;
    if (en_stop || act) held_d = 1'b0;
    else if (sample_lo) held_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_open <= 1'b0;
      held     <= 1'b0;
    end else begin
      acc_open <= open_d;
      held     <= held_d;
    end
  end
endmodule

// File: rtl/dmaq_xfer_fsm.sv
module dmaq_xfer_fsm
  import dmaq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_q,
  input  logic          held,
  input  logic          last,
  input  logic [AW-1:0] src_q,
  input  logic [AW-1:0] dst_q,
  input  logic          bus_gnt,
  input  logic [AW-1:0] bus_rdata,
  output logic          act,
  output logic          xfer_step,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [AW-1:0] bus_wdata
);
  xfer_st_e      st_q, st_d;
  logic [AW-1:0] data_q;
  logic          data_en, done_d;

  assign act       = (st_q == ST_IDLE) && held && en_q;
  assign xfer_step = (st_q == ST_WR);
  assign data_en   = (st_q == ST_RD);
  assign done_d    = xfer_step && last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (act) st_d = ST_ARB;
      ST_ARB:  if (bus_gnt) st_d = ST_RD;
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (data_en) data_q <= bus_rdata;
  end

  assign busy      = (st_q != ST_IDLE);
  assign bus_req   = busy;
  assign bus_rd    = (st_q == ST_RD);
  assign bus_wr    = (st_q == ST_WR);
  assign bus_addr  = bus_rd ? src_q : (bus_wr ? dst_q : '0);
  assign bus_wdata = bus_wr ? data_q : '0;
endmodule

// File: rtl/dmaq_level_dma.sv
module dmaq_level_dma #(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dreq_n,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  input  logic [AW-1:0] bus_rdata,
  output logic [AW-1:0] bus_wdata,
  output logic          done
);
  logic          en_q, lvl_q, en_start, en_stop, last;
  logic          act, xfer_step, busy, acc_open, held;
  logic [AW-1:0] src_q, dst_q;

  dmaq_ctrl_regs #(.AW(AW), .CW(CW), .STEP(STEP)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .xfer_step(xfer_step), .en_q(en_q), .lvl_q(lvl_q),
    .en_start(en_start), .en_stop(en_stop), .last(last),
    .src_q(src_q), .dst_q(dst_q)
  );

  dmaq_req_window u_win (
    .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .en_q(en_q), .lvl_q(lvl_q),
    .en_start(en_start), .en_stop(en_stop), .act(act), .xfer_step(xfer_step),
    .acc_open(acc_open), .held(held)
  );

  dmaq_xfer_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .held(held), .last(last),
    .src_q(src_q), .dst_q(dst_q), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .act(act), .xfer_step(xfer_step), .busy(busy), .done(done),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );
endmodule

// File: rtl/dmaq_level_dma_chk.sv
module dmaq_level_dma_chk (
  input logic clk,
  input logic rst_n,
  input logic dreq_n,
  input logic bus_req,
  input logic bus_gnt,
  input logic bus_rd,
  input logic bus_wr,
  input logic done,
  input logic en_q,
  input logic lvl_q,
  input logic acc_open,
  input logic held
);
  // R6
  strobe_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R6
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_wr && !bus_rd));

  // R6
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (!bus_wr && !bus_req));

  // R6
  rd_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> $past(bus_gnt));

  // R5
  req_from_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(held));

  // R7
  shut_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (!acc_open && !held));

  // R4
  held_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(acc_open && !dreq_n));

  // R2
  route_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_q && !held) |=> !held);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !en_q);
endmodule

bind dmaq_level_dma dmaq_level_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr), .done(done),
  .en_q(en_q), .lvl_q(lvl_q), .acc_open(acc_open), .held(held)
);

// File: tb/dmaq_level_dma_bench.sv
`timescale 1ns/1ps
module dmaq_level_dma_bench;
  localparam int AW = 16;
  localparam logic [AW-1:0] KEY = 16'h5A3C;

  typedef struct packed {
    logic        lvl;
    logic        sinc;
    logic        dinc;
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] cnt;
    logic [3:0]  gdly;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b1, 1'b1, 1'b1, 16'h1000, 16'h2000, 16'd3, 4'd0},
    '{1'b1, 1'b0, 1'b1, 16'h0040, 16'h3000, 16'd2, 4'd3},
    '{1'b1, 1'b1, 1'b0, 16'h0100, 16'h0800, 16'd4, 4'd1},
    '{1'b0, 1'b1, 1'b1, 16'h0200, 16'h0A00, 16'd2, 4'd0}
  };

  logic          clk, rst_n, cfg_wr, dreq_n, bus_req, bus_gnt, bus_rd, bus_wr, done;
  logic [1:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata, bus_addr, bus_rdata, bus_wdata;

  int n_chk, n_fail, nxfer, ndone, gap, cyc, gdly, gcnt;
  bit gap_armed, chk_gap;
  logic [AW-1:0] exp_src, exp_dst, exp_data;
  bit e_sinc, e_dinc;

  dmaq_level_dma u_dmaq_level_dma (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dreq_n(dreq_n), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign bus_rdata = bus_addr ^ KEY;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!bus_req) begin gcnt <= 0; bus_gnt <= 1'b0; end
    else begin gcnt <= gcnt + 1; bus_gnt <= (gcnt >= gdly); end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
    if (rst_n) begin
      if (done) ndone++;
      if (bus_rd) begin
        chk(bus_addr == exp_src, "R9 source address", int'(bus_addr), int'(exp_src));
        exp_data = exp_src ^ KEY;
      end
      if (bus_wr) begin
        chk(bus_addr == exp_dst, "R9 destination address", int'(bus_addr), int'(exp_dst));
        chk(bus_wdata == exp_data, "R6 write data", int'(bus_wdata), int'(exp_data));
        nxfer++;
        if (e_sinc) exp_src = exp_src + 16'd2;
        if (e_dinc) exp_dst = exp_dst + 16'd2;
        gap = 0;
        gap_armed = 1'b1;
      end else if (gap_armed) begin
        if (!bus_req) gap++;
        else begin
          if (chk_gap) chk(gap == 2, "R5 released cycles before next request", gap, 2);
          gap_armed = 1'b0;
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; dreq_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nxfer = 0; ndone = 0; gap_armed = 1'b0; chk_gap = 1'b0;
  endtask

  task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [AW-1:0] c,
                       input bit si, input bit di);
    exp_src = s; exp_dst = d; e_sinc = si; e_dinc = di;
    cfg_write(2'd1, s);
    cfg_write(2'd2, d);
    cfg_write(2'd3, c);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; gdly = 0;
    exp_src = '0; exp_dst = '0; exp_data = '0; e_sinc = 0; e_dinc = 0;
    do_reset();

    // R1: reset state and no activity without enabling
    @(negedge clk);
    chk({bus_req, bus_rd, bus_wr, done} == 4'b0, "R1 outputs after reset",
        int'({bus_req, bus_rd, bus_wr, done}), 0);
    dreq_n = 1'b0;
    repeat (10) @(negedge clk);
    chk(nxfer == 0 && !bus_req, "R1 no transfer while disabled", nxfer, 0);
    dreq_n = 1'b1;

    // Table-driven cases: R2, R5, R6, R8, R9
    for (int i = 0; i < 4; i++) begin
      do_reset();
      gdly = int'(VECS[i].gdly);
      setup(VECS[i].src, VECS[i].dst, VECS[i].cnt, VECS[i].sinc, VECS[i].dinc);
      chk_gap = 1'b1;
      dreq_n = 1'b0;
      cfg_write(2'd0, {12'd0, VECS[i].dinc, VECS[i].sinc, VECS[i].lvl, 1'b1});
      for (int k = 0; k < 300 && ndone == 0; k++) @(negedge clk);
      repeat (15) @(negedge clk);
      if (VECS[i].lvl) begin
        chk(nxfer == int'(VECS[i].cnt), "R8 transfer count", nxfer, int'(VECS[i].cnt));
        chk(ndone == 1, "R8 single done pulse", ndone, 1);
      end else begin
        chk(nxfer == 0, "R2 routing off gives no transfers", nxfer, 0);
        chk(ndone == 0, "R2 routing off gives no done", ndone, 0);
        cfg_write(2'd0, 16'd0);
      end
      dreq_n = 1'b1;
    end

    // R3: latency from enabling write with request already low
    do_reset();
    gdly = 0;
    setup(16'h0400, 16'h0500, 16'd1, 1'b1, 1'b1);
    dreq_n = 1'b0;
    cfg_write(2'd0, 16'h000F);
    chk(!bus_req, "R3 first cycle after write", int'(bus_req), 0);
    @(negedge clk);
    chk(!bus_req, "R3 second cycle after write", int'(bus_req), 0);
    @(negedge clk);
    chk(bus_req, "R3 third cycle after write", int'(bus_req), 1);
    repeat (20) @(negedge clk);
    chk(nxfer == 1 && ndone == 1, "R8 stops after single transfer", nxfer, 1);
    dreq_n = 1'b1;

    // R4 and R7: short pulses, and pulses while the window is closed
    do_reset();
    gdly = 5;
    setup(16'h0600, 16'h0700, 16'd4, 1'b1, 1'b1);
    cfg_write(2'd0, 16'h000F);
    repeat (3) @(negedge clk);
    dreq_n = 1'b0;
    @(negedge clk);
    dreq_n = 1'b1;
    repeat (25) @(negedge clk);
    chk(nxfer == 1, "R4 one-cycle low yields one transfer", nxfer, 1);
    dreq_n = 1'b0;
    @(negedge clk);
    dreq_n = 1'b1;
    for (int k = 0; k < 20 && !bus_req; k++) @(negedge clk);
    @(negedge clk);
    dreq_n = 1'b0;
    @(negedge clk);
    dreq_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(nxfer == 2, "R7 request during activation ignored", nxfer, 2);
    chk(ndone == 0, "R7 channel still running", ndone, 0);

    finish_run();
  end
endmodule